// File: doc/BRIEF.md
# Instruction Fetch Memory with Per-Bank Cache or SRAM Mode

This block sits between a processor's instruction fetch unit and its backing memory. It holds four identical storage banks. A configuration write places each bank in one of two modes. In the first mode the bank is a direct-mapped cache way of 64 one-word entries. In the second it is a 512-byte on-chip SRAM that answers at a programmable, 512-byte-aligned base address. Every bank in cache mode acts as one way of a single set-associative cache, so the cache can have from zero to four ways. Each bank also has a lock bit that freezes its contents.

The fetch port uses word addresses. The requester raises `fetch_req` and holds it, with a stable address, until `fetch_ready` is seen. SRAM hits and cache hits complete in the same cycle as the request. A miss starts a single-word read on the fill port, and the returned word goes to the processor in the cycle it arrives. SRAM contents are written through a separate word-load port.

Top module: `imb_array`

## Requirements
- R1: After reset, `fetch_ready` and `fill_req` are low. Every bank is in cache mode, unlocked, with base 0, and every entry is invalid, so the first fetch misses.
- R2: In the cycle after a fetch that hits nothing, `fill_req` goes high with `fill_wa` equal to the fetch word address. Both stay unchanged until `fill_valid`. In the `fill_valid` cycle, `fetch_ready` is 1 and `fetch_data` equals `fill_data`. `fill_req` is low in the next cycle.
- R3: A fetch that hits a valid cache entry gives `fetch_ready` with the stored word in the same cycle and raises no fill request.
- R4: The cache index is word-address bits [5:0] and the tag is all higher bits. Up to four addresses with the same index and different tags can be held at once, one per cache-mode bank.
- R5: A miss fill goes to the first eligible bank found by searching upward with wraparound from a rotating pointer. After an allocation, the pointer moves to the bank after the one chosen. The pointer is 0 after reset.
- R6: A locked cache-mode bank still serves hits but is never chosen for a fill.
- R7: If no cache-mode bank is unlocked, a miss still returns the fetched word but stores nothing, so a repeat of that fetch misses again.
- R8: A bank in SRAM mode with base field B (byte-address bits [31:9]) serves, in the same cycle, any fetch whose word-address bits [29:7] equal B. It returns the word stored at word-address bits [6:0]. Writing a new base moves the window, and the stored words are kept.
- R9: A fetch inside an SRAM window is served by the SRAM even if a cache way holds the same address, and no fill is raised. A cached copy in another bank survives and is served again once the SRAM bank leaves SRAM mode.
- R10: A configuration write that changes a bank's mode or base invalidates every cache entry of that bank. A write that changes only the lock bit keeps them.
- R11: A one-cycle pulse on `inv_all` invalidates every cache entry in every bank.
- R12: A `load_we` write changes only an SRAM-mode bank whose current window contains `load_wa`. A load to any other address leaves all SRAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank selected by the configuration write |
| cfg_sram | input | 1 | 1 = SRAM mode, 0 = cache mode |
| cfg_lock | input | 1 | Lock bit for the selected bank |
| cfg_base | input | 23 | SRAM window base, byte-address bits [31:9] |
| inv_all | input | 1 | Invalidate all cache entries |
| load_we | input | 1 | SRAM word write strobe |
| load_wa | input | 30 | SRAM word write address |
| load_data | input | 32 | SRAM word write data |
| fetch_req | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_wa | input | 30 | Fetch word address |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_data | output | 32 | Fetched instruction word |
| fill_req | output | 1 | External word read request |
| fill_wa | output | 30 | External read word address |
| fill_valid | input | 1 | External read data valid |
| fill_data | input | 32 | External read data |

## Verification
The bench puts several tags on one index, which stresses associativity and the rotating victim pointer. Wrong index or tag bits, or a pointer that does not move, show up as an expected hit that raises a fill, or as the wrong address being evicted. Lock handling is tested twice: with one bank locked, a locked bank that received a fill would lose its entry; with every bank locked, a design that allocates anyway would hit on a repeat fetch that must miss again. Invalidation is checked both ways. A lock-only write must keep the bank's entries, while a base change or a global invalidate must drop them. The SRAM tests move a window onto an address that is cached elsewhere and expect the SRAM word with no fill. They also load through a stale window, and a bank that ignored its current base would take that load.

// File: rtl/imb_pkg.sv
package imb_pkg;
    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } fetch_st_e;
endpackage

// File: rtl/imb_bank.sv
module imb_bank #(
    parameter int WA_W        = 30,
    parameter int CACHE_IDX_W = 6,
    parameter int SRAM_IDX_W  = 7,
    parameter int WORD_W      = 32,
    localparam int TAG_W       = WA_W - CACHE_IDX_W,
    localparam int BASE_W      = WA_W - SRAM_IDX_W,
    localparam int CACHE_WORDS = 1 << CACHE_IDX_W,
    localparam int SRAM_WORDS  = 1 << SRAM_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sram,
    input  logic [BASE_W-1:0] base_hi,
    input  logic              clear_valid,
    input  logic [WA_W-1:0]   look_wa,
    input  logic              fill_we,
    input  logic [WA_W-1:0]   fill_wa,
    input  logic [WORD_W-1:0] fill_word,
    input  logic              load_we,
    input  logic [WA_W-1:0]   load_wa,
    input  logic [WORD_W-1:0] load_word,
    output logic              sram_hit,
    output logic              cache_hit,
    output logic [WORD_W-1:0] rd_word
);
    // Shared word storage: cache mode uses the lower half, SRAM mode all of it.
    logic [WORD_W-1:0]      store_q [SRAM_WORDS];
    logic [TAG_W-1:0]       tag_q   [CACHE_WORDS];
    logic [CACHE_WORDS-1:0] valid_d, valid_q;

    logic [CACHE_IDX_W-1:0] look_idx, fill_idx;
    logic                   load_hit;

    assign look_idx = look_wa[CACHE_IDX_W-1:0];
    assign fill_idx = fill_wa[CACHE_IDX_W-1:0];
    assign load_hit = load_we && mode_sram && (load_wa[WA_W-1:SRAM_IDX_W] == base_hi);

    always_comb begin
        valid_d = valid_q;
        if (fill_we) valid_d[fill_idx] = 1'b1;
        if (clear_valid) valid_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            store_q[SRAM_IDX_W'(fill_idx)] <= fill_word;
            tag_q[fill_idx]                <= fill_wa[WA_W-1:CACHE_IDX_W];
        end else if (load_hit) begin
            store_q[load_wa[SRAM_IDX_W-1:0]] <= load_word;
        end
    end

    assign sram_hit  = mode_sram && (look_wa[WA_W-1:SRAM_IDX_W] == base_hi);
    assign cache_hit = !mode_sram && valid_q[look_idx]
                       && (tag_q[look_idx] == look_wa[WA_W-1:CACHE_IDX_W]);
    assign rd_word   = mode_sram ? store_q[look_wa[SRAM_IDX_W-1:0]]
                                 : store_q[SRAM_IDX_W'(look_idx)];
endmodule

// File: rtl/imb_victim.sv
module imb_victim #(
    parameter int NUM_BANKS = 4,
    localparam int WAY_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [NUM_BANKS-1:0] cand,
    input  logic [WAY_W-1:0]     ptr,
    output logic                 found,
    output logic [WAY_W-1:0]     way
);
    // Search upward from ptr with wraparound; the nearest candidate wins.
    always_comb begin
        found = 1'b0;
        way   = '0;
        for (int k = NUM_BANKS - 1; k >= 0; k--) begin
            int j;
            j = (int'(ptr) + k) % NUM_BANKS;
            if (cand[j]) begin
                found = 1'b1;
                way   = WAY_W'(j);
            end
        end
    end
endmodule

// File: rtl/imb_array.sv
module imb_array
    import imb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_BANKS   = 4,
    parameter int CACHE_IDX_W = 6,
    parameter int SRAM_IDX_W  = 7,
    parameter int WORD_W      = 32,
    localparam int WA_W   = ADDR_W - 2,
    localparam int BASE_W = WA_W - SRAM_IDX_W,
    localparam int WAY_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WAY_W-1:0]  cfg_bank,
    input  logic              cfg_sram,
    input  logic              cfg_lock,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic              inv_all,
    input  logic              load_we,
    input  logic [WA_W-1:0]   load_wa,
    input  logic [WORD_W-1:0] load_data,
    input  logic              fetch_req,
    input  logic [WA_W-1:0]   fetch_wa,
    output logic              fetch_ready,
    output logic [WORD_W-1:0] fetch_data,
    output logic              fill_req,
    output logic [WA_W-1:0]   fill_wa,
    input  logic              fill_valid,
    input  logic [WORD_W-1:0] fill_data
);
    typedef struct packed {
        fetch_st_e                           st;
        logic [WA_W-1:0]                     miss_wa;
        logic [WAY_W-1:0]                    rr;
        logic [NUM_BANKS-1:0]                sram_mode;
        logic [NUM_BANKS-1:0]                lock;
        logic [NUM_BANKS-1:0][BASE_W-1:0]    base;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_BANKS-1:0] sram_hit, cache_hit, fill_we, bank_clear;
    logic [WORD_W-1:0]    rd_word [NUM_BANKS];
    logic [WORD_W-1:0]    sram_word, cache_word;
    logic                 vic_found;
    logic [WAY_W-1:0]     vic_way, rr_next;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        imb_bank #(
            .WA_W        (WA_W),
            .CACHE_IDX_W (CACHE_IDX_W),
            .SRAM_IDX_W  (SRAM_IDX_W),
            .WORD_W      (WORD_W)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_sram   (ctl_q.sram_mode[b]),
            .base_hi     (ctl_q.base[b]),
            .clear_valid (bank_clear[b]),
            .look_wa     (fetch_wa),
            .fill_we     (fill_we[b]),
            .fill_wa     (ctl_q.miss_wa),
            .fill_word   (fill_data),
            .load_we     (load_we),
            .load_wa     (load_wa),
            .load_word   (load_data),
            .sram_hit    (sram_hit[b]),
            .cache_hit   (cache_hit[b]),
            .rd_word     (rd_word[b])
        );
    end

    imb_victim #(.NUM_BANKS(NUM_BANKS)) u_victim (
        .cand  (~ctl_q.sram_mode & ~ctl_q.lock),
        .ptr   (ctl_q.rr),
        .found (vic_found),
        .way   (vic_way)
    );

    assign rr_next = (vic_way == WAY_W'(NUM_BANKS - 1)) ? '0 : vic_way + 1'b1;

    // Lowest-numbered matching bank supplies the word.
    always_comb begin
        sram_word  = '0;
        cache_word = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (sram_hit[b])  sram_word  = rd_word[b];
            if (cache_hit[b]) cache_word = rd_word[b];
        end
    end

    always_comb begin
        ctl_d       = ctl_q;
        bank_clear  = {NUM_BANKS{inv_all}};
        fill_we     = '0;
        fetch_ready = 1'b0;
        fetch_data  = '0;

        if (cfg_we) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (WAY_W'(b) == cfg_bank) begin
                    if (ctl_q.sram_mode[b] != cfg_sram || ctl_q.base[b] != cfg_base)
                        bank_clear[b] = 1'b1;
                    ctl_d.sram_mode[b] = cfg_sram;
                    ctl_d.lock[b]      = cfg_lock;
                    ctl_d.base[b]      = cfg_base;
                end
            end
        end

        case (ctl_q.st)
            ST_LOOKUP: begin
                if (fetch_req) begin
                    if (|sram_hit) begin
                        fetch_ready = 1'b1;
                        fetch_data  = sram_word;
                    end else if (|cache_hit) begin
                        fetch_ready = 1'b1;
                        fetch_data  = cache_word;
                    end else begin
                        ctl_d.st      = ST_FILL;
                        ctl_d.miss_wa = fetch_wa;
                    end
                end
            end
            ST_FILL: begin
                if (fill_valid) begin
                    fetch_ready = 1'b1;
                    fetch_data  = fill_data;
                    ctl_d.st    = ST_LOOKUP;
                    if (vic_found) begin
                        fill_we[vic_way] = 1'b1;
                        ctl_d.rr         = rr_next;
                    end
                end
            end
            default: ctl_d.st = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign fill_req = (ctl_q.st == ST_FILL);
    assign fill_wa  = ctl_q.miss_wa;
endmodule

// File: rtl/imb_array_chk.sv
module imb_array_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    localparam int WA_W = ADDR_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic [WA_W-1:0]   fetch_wa,
    input logic              fetch_ready,
    input logic [WORD_W-1:0] fetch_data,
    input logic              fill_req,
    input logic [WA_W-1:0]   fill_wa,
    input logic              fill_valid,
    input logic [WORD_W-1:0] fill_data
);
    a_r2_miss_starts_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ready && !fill_req) |=> fill_req);

    a_r2_fill_addr_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ready && !fill_req) |=> (fill_wa == $past(fetch_wa)));

    a_r2_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_wa)));

    a_r2_fill_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_valid) |-> (fetch_ready && fetch_data == fill_data));

    a_r2_fill_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_valid) |=> !fill_req);

    a_r3_hit_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready && !fill_req) |=> !fill_req);

    a_r3_ready_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> (fetch_req || fill_req));
endmodule

bind imb_array imb_array_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .fetch_wa    (fetch_wa),
    .fetch_ready (fetch_ready),
    .fetch_data  (fetch_data),
    .fill_req    (fill_req),
    .fill_wa     (fill_wa),
    .fill_valid  (fill_valid),
    .fill_data   (fill_data)
);

// File: tb/test_imb_array.sv
module test_imb_array;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic        cfg_sram = 1'b0;
    logic        cfg_lock = 1'b0;
    logic [22:0] cfg_base = '0;
    logic        inv_all = 1'b0;
    logic        load_we = 1'b0;
    logic [29:0] load_wa = '0;
    logic [31:0] load_data = '0;
    logic        fetch_req = 1'b0;
    logic [29:0] fetch_wa = '0;
    logic        fetch_ready;
    logic [31:0] fetch_data;
    logic        fill_req;
    logic [29:0] fill_wa;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    imb_array i_imb_array (.*);

    typedef struct {
        logic [31:0] data;
        bit          miss;
        logic [29:0] wa;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    function automatic logic [31:0] backing(input logic [29:0] wa);
        return {wa, 2'b00} ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [31:0] sw(input int i);
        return 32'hC0DE_0000 | i;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Driver: pushes the expectation, then holds the request until ready.
    task automatic fetch(input logic [31:0] addr, input logic [31:0] exp_data, input bit exp_miss, input string req);
        exp_t e;
        e.data = exp_data;
        e.miss = exp_miss;
        e.wa   = addr[31:2];
        e.req  = req;
        exp_q.push_back(e);
        fetch_req = 1'b1;
        fetch_wa  = addr[31:2];
        do @(negedge clk); while (!fetch_ready);
        @(posedge clk); #1;
        fetch_req = 1'b0;
    endtask

    task automatic cfg(input int bank, input bit sram, input bit lock, input logic [31:0] base_addr);
        cfg_we   = 1'b1;
        cfg_bank = 2'(bank);
        cfg_sram = sram;
        cfg_lock = lock;
        cfg_base = base_addr[31:9];
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic load(input logic [31:0] addr, input logic [31:0] data);
        load_we   = 1'b1;
        load_wa   = addr[31:2];
        load_data = data;
        @(posedge clk); #1;
        load_we = 1'b0;
    endtask

    task automatic pulse_inv();
        inv_all = 1'b1;
        @(posedge clk); #1;
        inv_all = 1'b0;
    endtask

    // Backing-memory responder, latency 1 or 3 cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && fill_req) begin
                repeat (fill_wa[0] ? 2 : 0) @(posedge clk);
                @(posedge clk); #1;
                fill_valid = 1'b1;
                fill_data  = backing(fill_wa);
                @(posedge clk); #1;
                fill_valid = 1'b0;
            end
        end
    end

    // Monitor: pops one expectation per completed fetch.
    initial begin
        bit          saw_fill;
        logic [29:0] seen_wa;
        saw_fill = 1'b0;
        seen_wa  = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (fill_req) begin
                    saw_fill = 1'b1;
                    seen_wa  = fill_wa;
                end
                if (fetch_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected ready", 32'(fetch_ready), 32'd0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(fetch_data === e.data, {e.req, " data"}, fetch_data, e.data);
                        chk(saw_fill == e.miss, {e.req, " miss flag"}, 32'(saw_fill), 32'(e.miss));
                        if (e.miss && saw_fill)
                            chk(seen_wa == e.wa, {e.req, " R2 fill address"}, 32'(seen_wa), 32'(e.wa));
                    end
                    saw_fill = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    localparam logic [31:0] A = 32'h1000_0044, B = 32'h2000_0044, C = 32'h3000_0044,
                            D = 32'h4000_0044, E = 32'h5000_0044, F = 32'h6000_0044,
                            G = 32'h7000_0044;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(fetch_ready == 1'b0, "R1 reset ready", 32'(fetch_ready), 32'd0);
        chk(fill_req == 1'b0, "R1 reset fill_req", 32'(fill_req), 32'd0);
        @(posedge clk); #1;

        // R1/R2 cold miss, R3 hit
        fetch(A, backing(A[31:2]), 1, "R1 R2 cold miss A");
        fetch(A, backing(A[31:2]), 0, "R3 hit A");
        // R4 four tags on one index
        fetch(B, backing(B[31:2]), 1, "R4 miss B");
        fetch(C, backing(C[31:2]), 1, "R4 miss C");
        fetch(D, backing(D[31:2]), 1, "R4 miss D");
        fetch(A, backing(A[31:2]), 0, "R4 hit A");
        fetch(B, backing(B[31:2]), 0, "R4 hit B");
        fetch(C, backing(C[31:2]), 0, "R4 hit C");
        fetch(D, backing(D[31:2]), 0, "R4 hit D");
        // R5 round robin evicts A (bank0)
        fetch(E, backing(E[31:2]), 1, "R5 miss E");
        fetch(B, backing(B[31:2]), 0, "R5 hit B");
        fetch(E, backing(E[31:2]), 0, "R5 hit E");
        fetch(A, backing(A[31:2]), 1, "R5 A evicted");
        // banks: 0=E 1=A 2=C 3=D, pointer 2
        cfg(2, 0, 1, 32'h0);
        fetch(C, backing(C[31:2]), 0, "R10 lock-only keeps C");
        fetch(F, backing(F[31:2]), 1, "R6 miss F skips locked bank");
        fetch(C, backing(C[31:2]), 0, "R6 locked C kept");
        fetch(D, backing(D[31:2]), 1, "R6 D evicted from bank3");
        fetch(C, backing(C[31:2]), 0, "R6 locked C still kept");
        // banks: 0=D 1=A 2=C 3=F, pointer 1; lock all
        cfg(0, 0, 1, 32'h0);
        cfg(1, 0, 1, 32'h0);
        cfg(3, 0, 1, 32'h0);
        fetch(G, backing(G[31:2]), 1, "R7 all locked miss G");
        fetch(G, backing(G[31:2]), 1, "R7 G not allocated");
        fetch(D, backing(D[31:2]), 0, "R7 D kept");
        for (int b = 0; b < 4; b++) cfg(b, 0, 0, 32'h0);
        // R10 base change on bank0 drops D
        cfg(0, 0, 0, 32'h0000_1000);
        fetch(D, backing(D[31:2]), 1, "R10 base change drops D");
        fetch(D, backing(D[31:2]), 0, "R10 D refilled");
        fetch(F, backing(F[31:2]), 0, "R10 other bank F kept");
        // R11 global invalidate
        pulse_inv();
        fetch(C, backing(C[31:2]), 1, "R11 C invalidated");
        fetch(C, backing(C[31:2]), 0, "R11 C refilled");
        fetch(F, backing(F[31:2]), 1, "R11 F invalidated");
        // R8 SRAM window at 0x0002_0000 on bank1
        cfg(1, 1, 0, 32'h0002_0000);
        load(32'h0002_0000, sw(0));
        load(32'h0002_0044, sw(17));
        load(32'h0002_01FC, sw(127));
        load(32'h0002_0010, sw(4));
        fetch(32'h0002_0000, sw(0), 0, "R8 SRAM word 0");
        fetch(32'h0002_01FC, sw(127), 0, "R8 SRAM word 127");
        fetch(32'h0002_0200, backing(30'h0000_8080), 1, "R8 outside window misses");
        fetch(D, backing(D[31:2]), 1, "R9 D cached in other bank");
        fetch(D, backing(D[31:2]), 0, "R9 D hit");
        // R8/R9 relocate window over D
        cfg(1, 1, 0, 32'h4000_0000);
        fetch(D, sw(17), 0, "R9 SRAM wins over cached D");
        fetch(32'h4000_0000, sw(0), 0, "R8 relocated word 0");
        load(32'h0002_0010, 32'hDEAD_BEEF);
        load(32'h4000_0014, 32'h1234_5678);
        fetch(32'h4000_0010, sw(4), 0, "R12 stale-window load ignored");
        fetch(32'h4000_0014, 32'h1234_5678, 0, "R12 in-window load taken");
        cfg(1, 0, 0, 32'h0);
        fetch(D, backing(D[31:2]), 0, "R9 cached D served again");

        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "R3 all fetches completed", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule